// File: doc/BRIEF.md
# Next Fetch Block Selector with Predicted Decode

This block is the last stage of a fetch address generator. Each cycle it holds the current fetch block and the decode information predicted for it. From that prediction it picks the address of the next block: the sequential fallthrough, a branch-target-buffer target, an indirect-jump target, or the top of a small return stack. Decoded instructions arrive far too late for this choice, so the block's exit kind and exit slot are always predicted.

The predicted decode for the next block comes from one of three places. For a taken transfer it is supplied alongside the target by the target buffer or the jump predictor. For a return it is read from an internal return-decode table, addressed with the stack top one cycle early. For a fallthrough it is read from an internal two-ahead table addressed with the block before, or after a taken transfer it is the value the transfer's entry carried for the block after the target. After a misprediction, a checkpoint reloads every register that feeds the selection, so fetch resumes at once without reading any table.

Top module: `fetch_next_sel`

## Requirements
- R1: While reset is held, blk_addr equals RESET_ADDR and blk_dec, fall_dec, ret_dec and ras_ptr are all zero.
- R2: A decode word has the exit kind in bits [2:0] and the exit slot in the bits above. Kind codes are 0 fallthrough, 1 taken conditional, 2 jump, 3 call and 4 return, and codes 5 to 7 act as fallthrough. On an advancing cycle the next blk_addr is chosen by kind: the aligned base plus 2^SLOT_W for fallthrough, btb_target for conditional and call, jmp_target for jump, and the return stack top for return.
- R3: On an advancing cycle the next blk_dec is chosen by kind: btb_dec for conditional and call, jmp_dec for jump, ret_dec for return, and fall_dec otherwise.
- R4: On an advancing cycle fall_dec takes btb_ft_dec after a conditional or call and jmp_ft_dec after a jump. Otherwise it takes the two-ahead table entry indexed by the current block number, where the block number is blk_addr bits [SLOT_W+IDX_W-1:SLOT_W].
- R5: Every cycle that does not restore, ret_dec takes the return-decode table entry indexed by the block number of the stack top as it stood at the start of that cycle. As a result, a return in the block right after its call uses the entry of the older top.
- R6: A call pushes its aligned base plus slot plus one, and a return pops. The stack is circular with RAS_DEPTH entries, ras_ptr wraps modulo RAS_DEPTH, and on overflow the oldest entry is overwritten.
- R7: While adv is low and no restore is applied, blk_addr, blk_dec, fall_dec and ras_ptr hold their values.
- R8: ckpt_valid has priority over adv. It loads blk_addr, blk_dec, fall_dec, ret_dec and ras_ptr from the checkpoint inputs, and no push or pop happens.
- R9: A table write at index i becomes visible to reads in the following cycle. Each table has TAB_DEPTH entries and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance to the next block |
| btb_target | input | ADDR_W | Target from the target buffer |
| btb_dec | input | DEC_W | Predicted decode of that target block |
| btb_ft_dec | input | DEC_W | Predicted decode of the block after that target |
| jmp_target | input | ADDR_W | Target from the jump predictor |
| jmp_dec | input | DEC_W | Predicted decode of the jump target block |
| jmp_ft_dec | input | DEC_W | Predicted decode of the block after the jump target |
| ckpt_valid | input | 1 | Restore from checkpoint |
| ckpt_addr | input | ADDR_W | Restored block address |
| ckpt_dec | input | DEC_W | Restored block decode |
| ckpt_fall_dec | input | DEC_W | Restored fallthrough decode |
| ckpt_ret_dec | input | DEC_W | Restored return decode |
| ckpt_ras_ptr | input | PTR_W | Restored stack pointer |
| rdt_we | input | 1 | Return-decode table write enable |
| rdt_widx | input | IDX_W | Return-decode table write index |
| rdt_wdata | input | DEC_W | Return-decode table write data |
| t2_we | input | 1 | Two-ahead table write enable |
| t2_widx | input | IDX_W | Two-ahead table write index |
| t2_wdata | input | DEC_W | Two-ahead table write data |
| blk_addr | output | ADDR_W | Current fetch block address |
| blk_dec | output | DEC_W | Predicted decode of the current block |
| fall_dec | output | DEC_W | Staged fallthrough decode, for checkpointing |
| ret_dec | output | DEC_W | Staged return decode, for checkpointing |
| ras_ptr | output | PTR_W | Return stack pointer, for checkpointing |

## Verification
The bench builds the block with ADDR_W=10, SLOT_W=2, RAS_DEPTH=8, TAB_DEPTH=64 and a nonzero reset address. A 10-bit address leaves only 256 blocks, so long random runs revisit table entries often and produce aliasing between blocks. The same runs wrap the 8-deep stack, reach every kind code including 5 to 7, and mix stalls, restores and table writes. Directed phases add a call followed directly by a return, a chain of nine calls followed by returns, and a read of a table write in the following cycle.

// File: rtl/fns_pkg.sv
package fns_pkg;
    localparam logic [2:0] EX_FALL = 3'd0;
    localparam logic [2:0] EX_COND = 3'd1;
    localparam logic [2:0] EX_JUMP = 3'd2;
    localparam logic [2:0] EX_CALL = 3'd3;
    localparam logic [2:0] EX_RET  = 3'd4;
endpackage

// File: rtl/fns_dec_table.sv
module fns_dec_table #(
    parameter int DEPTH = 64,
    parameter int W     = 5,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[ridx];

    // R9: a write is visible on the next cycle
    a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ridx == widx) |=> (rdata == $past(wdata) || $past(ridx) != ridx));
endmodule

// File: rtl/fns_ret_stack.sv
module fns_ret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    input  logic          restore,
    input  logic [PW-1:0] restore_ptr,
    output logic [AW-1:0] top,
    output logic [PW-1:0] ptr
);
    logic [AW-1:0] mem_q [DEPTH];
    logic [AW-1:0] mem_d [DEPTH];
    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        mem_d = mem_q;
        ptr_d = ptr_q;
        if (restore) begin
            ptr_d = restore_ptr;
        end else if (push) begin
            ptr_d        = ptr_q + PW'(1);
            mem_d[ptr_d] = push_val;
        end else if (pop) begin
            ptr_d = ptr_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            ptr_q <= '0;
        end else begin
            mem_q <= mem_d;
            ptr_q <= ptr_d;
        end
    end

    assign top = mem_q[ptr_q];
    assign ptr = ptr_q;

    // R6: a pushed value becomes the top
    a_r6_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !restore) |=> top == $past(push_val));
    // R6: a pop steps the pointer back with wrap
    a_r6_pop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !restore) |=> ptr == $past(ptr) - PW'(1));
endmodule

// File: rtl/fetch_next_sel.sv
module fetch_next_sel
    import fns_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SLOT_W    = 2,
    parameter int RAS_DEPTH = 8,
    parameter int TAB_DEPTH = 64,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int DEC_W = 3 + SLOT_W,
    localparam int IDX_W = $clog2(TAB_DEPTH),
    localparam int PTR_W = $clog2(RAS_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic [DEC_W-1:0]  btb_dec,
    input  logic [DEC_W-1:0]  btb_ft_dec,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic [DEC_W-1:0]  jmp_dec,
    input  logic [DEC_W-1:0]  jmp_ft_dec,
    input  logic              ckpt_valid,
    input  logic [ADDR_W-1:0] ckpt_addr,
    input  logic [DEC_W-1:0]  ckpt_dec,
    input  logic [DEC_W-1:0]  ckpt_fall_dec,
    input  logic [DEC_W-1:0]  ckpt_ret_dec,
    input  logic [PTR_W-1:0]  ckpt_ras_ptr,
    input  logic              rdt_we,
    input  logic [IDX_W-1:0]  rdt_widx,
    input  logic [DEC_W-1:0]  rdt_wdata,
    input  logic              t2_we,
    input  logic [IDX_W-1:0]  t2_widx,
    input  logic [DEC_W-1:0]  t2_wdata,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [DEC_W-1:0]  blk_dec,
    output logic [DEC_W-1:0]  fall_dec,
    output logic [DEC_W-1:0]  ret_dec,
    output logic [PTR_W-1:0]  ras_ptr
);
    localparam int BLK = 1 << SLOT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DEC_W-1:0]  dec;
        logic [DEC_W-1:0]  fall;
        logic [DEC_W-1:0]  ret;
    } sel_st_t;

    sel_st_t st_q, st_d;

    logic [2:0]        kind;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] base, ft_addr, call_ret;
    logic [ADDR_W-1:0] nxt_addr, ras_top;
    logic [DEC_W-1:0]  nxt_dec, nxt_fall, t2_rdata, rdt_rdata;
    logic              do_push, do_pop;

    fns_dec_table #(.DEPTH(TAB_DEPTH), .W(DEC_W)) u_t2_tab (
        .clk(clk), .rst_n(rst_n), .we(t2_we), .widx(t2_widx), .wdata(t2_wdata),
        .ridx(st_q.addr[SLOT_W +: IDX_W]), .rdata(t2_rdata)
    );

    fns_dec_table #(.DEPTH(TAB_DEPTH), .W(DEC_W)) u_rdt_tab (
        .clk(clk), .rst_n(rst_n), .we(rdt_we), .widx(rdt_widx), .wdata(rdt_wdata),
        .ridx(ras_top[SLOT_W +: IDX_W]), .rdata(rdt_rdata)
    );

    fns_ret_stack #(.DEPTH(RAS_DEPTH), .AW(ADDR_W)) u_ras (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .push_val(call_ret),
        .restore(ckpt_valid), .restore_ptr(ckpt_ras_ptr), .top(ras_top), .ptr(ras_ptr)
    );

    always_comb begin
        kind     = st_q.dec[2:0];
        slot     = st_q.dec[DEC_W-1:3];
        base     = {st_q.addr[ADDR_W-1:SLOT_W], SLOT_W'(0)};
        ft_addr  = base + ADDR_W'(BLK);
        call_ret = base + ADDR_W'(slot) + ADDR_W'(1);
        nxt_addr = ft_addr;
        nxt_dec  = st_q.fall;
        nxt_fall = t2_rdata;
        case (kind)
            EX_COND, EX_CALL: begin
                nxt_addr = btb_target;
                nxt_dec  = btb_dec;
                nxt_fall = btb_ft_dec;
            end
            EX_JUMP: begin
                nxt_addr = jmp_target;
                nxt_dec  = jmp_dec;
                nxt_fall = jmp_ft_dec;
            end
            EX_RET: begin
                nxt_addr = ras_top;
                nxt_dec  = st_q.ret;
            end
            default: ;
        endcase
        do_push = adv && !ckpt_valid && kind == EX_CALL;
        do_pop  = adv && !ckpt_valid && kind == EX_RET;

        st_d     = st_q;
        st_d.ret = rdt_rdata;
        if (ckpt_valid) begin
            st_d.addr = ckpt_addr;
            st_d.dec  = ckpt_dec;
            st_d.fall = ckpt_fall_dec;
            st_d.ret  = ckpt_ret_dec;
        end else if (adv) begin
            st_d.addr = nxt_addr;
            st_d.dec  = nxt_dec;
            st_d.fall = nxt_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: RESET_ADDR, dec: '0, fall: '0, ret: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_addr = st_q.addr;
    assign blk_dec  = st_q.dec;
    assign fall_dec = st_q.fall;
    assign ret_dec  = st_q.ret;

    // R2: a return block goes to the stack top
    a_r2_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ckpt_valid && kind == EX_RET) |=> blk_addr == $past(ras_top));
    // R3: a jump block takes the jump predictor's decode
    a_r3_jump_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ckpt_valid && kind == EX_JUMP) |=> blk_dec == $past(jmp_dec));
    // R7: a stall holds the block
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ckpt_valid) |=> ($stable(blk_addr) && $stable(blk_dec) && $stable(ras_ptr)));
    // R8: a restore loads the checkpoint
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_valid |=> (blk_addr == $past(ckpt_addr) && ras_ptr == $past(ckpt_ras_ptr)
                        && ret_dec == $past(ckpt_ret_dec)));
endmodule

// File: tb/fetch_next_sel_bench.sv
`timescale 1ns/1ps
module fetch_next_sel_bench;
    localparam int AW = 10, SW = 2, DW = 5, IW = 6, PW = 3;
    localparam logic [AW-1:0] RST_A = 10'h040;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic          adv = 0, ckpt_valid = 0, rdt_we = 0, t2_we = 0;
    logic [AW-1:0] btb_target = 0, jmp_target = 0, ckpt_addr = 0;
    logic [DW-1:0] btb_dec = 0, btb_ft_dec = 0, jmp_dec = 0, jmp_ft_dec = 0;
    logic [DW-1:0] ckpt_dec = 0, ckpt_fall_dec = 0, ckpt_ret_dec = 0, rdt_wdata = 0, t2_wdata = 0;
    logic [PW-1:0] ckpt_ras_ptr = 0;
    logic [IW-1:0] rdt_widx = 0, t2_widx = 0;
    logic [AW-1:0] blk_addr;
    logic [DW-1:0] blk_dec, fall_dec, ret_dec;
    logic [PW-1:0] ras_ptr;

    fetch_next_sel #(.ADDR_W(AW), .SLOT_W(SW), .RAS_DEPTH(8), .TAB_DEPTH(64), .RESET_ADDR(RST_A))
    u_fetch_next_sel (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [AW-1:0] m_addr, m_stk [8];
    logic [DW-1:0] m_dec, m_fall, m_ret, m_rdt [64], m_t2 [64];
    logic [PW-1:0] m_ptr;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(string ta, string td, string tf, string tr, string tp);
        chk(ta, 32'(blk_addr), 32'(m_addr));
        chk(td, 32'(blk_dec), 32'(m_dec));
        chk(tf, 32'(fall_dec), 32'(m_fall));
        chk(tr, 32'(ret_dec), 32'(m_ret));
        chk(tp, 32'(ras_ptr), 32'(m_ptr));
    endtask

    // One clock: model next state from the requirements, then compare.
    task automatic step();
        logic [2:0] k;
        logic [AW-1:0] base, top, n_addr;
        logic [DW-1:0] n_dec, n_fall, n_ret;
        logic [PW-1:0] n_ptr;
        k = m_dec[2:0];
        base = {m_addr[AW-1:SW], 2'b00};
        top = m_stk[m_ptr];
        n_addr = m_addr; n_dec = m_dec; n_fall = m_fall; n_ptr = m_ptr;
        n_ret = m_rdt[top[SW +: IW]];
        if (ckpt_valid) begin
            n_addr = ckpt_addr; n_dec = ckpt_dec; n_fall = ckpt_fall_dec;
            n_ret = ckpt_ret_dec; n_ptr = ckpt_ras_ptr;
        end else if (adv) begin
            if (k == 3'd1 || k == 3'd3) begin
                n_addr = btb_target; n_dec = btb_dec; n_fall = btb_ft_dec;
            end else if (k == 3'd2) begin
                n_addr = jmp_target; n_dec = jmp_dec; n_fall = jmp_ft_dec;
            end else if (k == 3'd4) begin
                n_addr = top; n_dec = m_ret; n_fall = m_t2[m_addr[SW +: IW]];
            end else begin
                n_addr = base + 10'd4; n_dec = m_fall; n_fall = m_t2[m_addr[SW +: IW]];
            end
            if (k == 3'd3) begin
                n_ptr = m_ptr + 3'd1;
                m_stk[n_ptr] = base + AW'(m_dec[4:3]) + 10'd1;
            end else if (k == 3'd4) begin
                n_ptr = m_ptr - 3'd1;
            end
        end
        if (rdt_we) m_rdt[rdt_widx] = rdt_wdata;
        if (t2_we) m_t2[t2_widx] = t2_wdata;
        @(posedge clk); #1;
        m_addr = n_addr; m_dec = n_dec; m_fall = n_fall; m_ret = n_ret; m_ptr = n_ptr;
        if (ckpt_valid) cmp_all("R8 addr", "R8 dec", "R8 fall", "R8 ret", "R8 ptr");
        else if (!adv) cmp_all("R7 addr", "R7 dec", "R7 fall", "R5 ret", "R7 ptr");
        else cmp_all("R2 addr", "R3 dec", "R4 fall", "R5 ret", "R6 ptr");
        @(negedge clk);
    endtask

    task automatic quiet();
        adv = 0; ckpt_valid = 0; rdt_we = 0; t2_we = 0;
    endtask

    task automatic randomize_inputs();
        btb_target = AW'($urandom); jmp_target = AW'($urandom);
        btb_dec = DW'($urandom); btb_ft_dec = DW'($urandom);
        jmp_dec = DW'($urandom); jmp_ft_dec = DW'($urandom);
        adv = ($urandom % 100) < 85;
        ckpt_valid = ($urandom % 100) < 3;
        ckpt_addr = AW'($urandom); ckpt_dec = DW'($urandom);
        ckpt_fall_dec = DW'($urandom); ckpt_ret_dec = DW'($urandom);
        ckpt_ras_ptr = PW'($urandom);
        rdt_we = ($urandom % 100) < 30; rdt_widx = IW'($urandom); rdt_wdata = DW'($urandom);
        t2_we = ($urandom % 100) < 30; t2_widx = IW'($urandom); t2_wdata = DW'($urandom);
    endtask

    initial begin
        #(5.0 * 60000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] xa, ra;
        m_addr = RST_A; m_dec = 0; m_fall = 0; m_ret = 0; m_ptr = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
        for (int i = 0; i < 64; i++) begin m_rdt[i] = 0; m_t2[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp_all("R1 addr", "R1 dec", "R1 fall", "R1 ret", "R1 ptr");
        rst_n = 1;
        @(negedge clk);

        // Fallthrough chain from reset with an empty two-ahead table (R2, R4)
        adv = 1;
        repeat (4) step();

        // R5: call then immediate return uses the decode of the older top
        quiet();
        xa = 10'h120;                      // call block, slot 2
        ra = xa + 10'd3;                   // pushed return address
        rdt_we = 1; rdt_widx = ra[SW +: IW]; rdt_wdata = 5'b01_010;
        step();
        rdt_widx = m_stk[m_ptr][SW +: IW]; rdt_wdata = 5'b11_001;
        step();
        quiet();
        ckpt_valid = 1; ckpt_addr = xa; ckpt_dec = {2'd2, 3'd3};
        ckpt_fall_dec = 0; ckpt_ret_dec = 5'b11_001; ckpt_ras_ptr = m_ptr;
        step();
        quiet(); adv = 1; btb_target = 10'h200; btb_dec = {2'd1, 3'd4}; btb_ft_dec = 0;
        step();                            // call advances, next block is a return
        step();                            // return: decode staged from older top
        chk("R5 call-return decode", 32'(blk_dec), 32'(5'b11_001));
        chk("R5 return target", 32'(blk_addr), 32'(ra));

        // R6: nine calls wrap the 8-deep stack, then returns walk it back
        quiet();
        ckpt_valid = 1; ckpt_addr = 10'h300; ckpt_dec = {2'd0, 3'd3}; ckpt_ras_ptr = 3'd0;
        ckpt_fall_dec = 0; ckpt_ret_dec = 0;
        step();
        quiet(); adv = 1;
        for (int i = 0; i < 9; i++) begin
            btb_target = AW'(10'h040 + 10'(i * 8)); btb_dec = {2'(i), 3'd3};
            step();
        end
        chk("R6 wrap pointer", 32'(ras_ptr), 32'd1);
        quiet();
        for (int i = 0; i < 64; i++) begin
            rdt_we = 1; rdt_widx = IW'(i); rdt_wdata = {2'(i), 3'd4};
            step();
        end
        quiet();
        ckpt_valid = 1; ckpt_addr = m_addr; ckpt_dec = {2'd0, 3'd4};
        ckpt_fall_dec = 0; ckpt_ret_dec = {2'd0, 3'd4}; ckpt_ras_ptr = m_ptr;
        step();
        quiet(); adv = 1;
        repeat (10) step();

        // R9: a table write is read the next cycle
        quiet();
        rdt_we = 1; rdt_widx = m_stk[m_ptr][SW +: IW]; rdt_wdata = 5'h1C;
        step();
        quiet();
        step();
        chk("R9 table write visible", 32'(ret_dec), 32'h1C);

        // Long mixed sweep over all kinds, stalls, restores and table writes
        for (int n = 0; n < 6000; n++) begin
            randomize_inputs();
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule